// File: doc/BRIEF.md
# VLIW Exception Queue and Prioritizer

This block gathers the exception and interrupt requests raised by the instructions of one VLIW packet while the packet executes. Each instruction slot has its own small store. When the packet-end strobe arrives, the block selects the single most urgent request and emits a one-cycle handler-select pulse. The pulse carries the winning kind, its class, a packed exception status word, the address of the faulting instruction and, for data-side faults, the data address.

Kinds are numbered 0 to 35 in rising urgency. Codes 0..14 are external levels 1..15. Code 15 is the trap instruction. Codes 16..33 are the program exceptions, in order: commit, division, data store error, data access exception, data MMU miss, data access error, media exception, FP exception, misaligned address, register exception, media disabled, FP disabled, privileged, illegal, instruction access exception, instruction access error, instruction MMU miss, compound. Code 34 is break and code 35 is reset. Because the numeric kind code is also the priority, a comparison of two codes settles which request is more urgent. The class follows from the kind.

The downstream handler logic uses the pulse to choose a vector. The queue empties itself in the cycle after the pulse, ready for the next packet.

Top module: `vliw_exc_queue`

## Requirements
- R1: After reset `hnd_valid` and `ovf` are 0 and every slot store is empty, so a packet end with no requests gives no pulse.
- R2: A packet end while the queue holds at least one entry raises `hnd_valid` for exactly one cycle, in the cycle after the strobe. A packet end on an empty queue raises nothing.
- R3: The winner is the stored entry with the highest kind code. `hnd_class` is 0 for kinds 0..14, 1 for kind 15, 2 for kinds 16..33, 3 for kind 34 and 4 for kind 35.
- R4: Among entries of equal kind, the lowest slot wins, and within a slot the earliest accepted entry wins. `hnd_pc` shows the winner's instruction address.
- R5: `hnd_status` bit 0 is 1 and bits 5:1 hold the 5-bit code. The codes are: commit 0x14, division 0x13, data store error 0x00, data access exception 0x12, data MMU miss 0x11, data access error 0x10, media exception 0x0E, FP exception 0x0D, misaligned 0x0B, register exception 0x0C, media disabled 0x07, FP disabled 0x06, privileged 0x04, illegal 0x05, instruction access exception 0x03, instruction access error 0x02, instruction MMU miss 0x01. Every other kind gives 0x1F.
- R6: For a register exception winner, status bits 7:6 carry the 2-bit sub-code (0 unimplemented, 1 unaligned). For an instruction access exception winner, bit 8 carries sub-code bit 0. For a data access exception winner, bit 9 carries sub-code bit 0. All other status bits are 0.
- R7: Status bit 11 is set, and `hnd_addr` carries the captured data address, only when the winner is kind 19, 20, 21 or 24. Otherwise bit 11 is 0 and `hnd_addr` is 0.
- R8: `hnd_div` carries the 2-bit sub-code (0 none, 1 divide by zero, 2 overflow, 3 both) when the winner is a division exception (kind 17), and is 0 otherwise.
- R9: Each slot stores at most 4 requests. A request to a full slot is dropped and sets `ovf`, which stays set until reset.
- R10: The queue is emptied in the cycle after the pulse, so a later packet end with no new requests gives no pulse.
- R11: Requests with a kind code above 35 are not stored. Requests presented in the packet-end cycle or in the pulse cycle are also not stored, and `ovf` is not set by them.
- R12: While `hnd_valid` is 0, `hnd_kind`, `hnd_class`, `hnd_status`, `hnd_pc`, `hnd_addr` and `hnd_div` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | SLOTS | Per-slot request strobe |
| req_kind | input | SLOTS x 6 | Per-slot kind code (priority order) |
| req_pc | input | SLOTS x 32 | Per-slot instruction address |
| req_addr | input | SLOTS x 32 | Per-slot data address |
| req_sub | input | SLOTS x 2 | Per-slot sub-code |
| pkt_end | input | 1 | End-of-packet strobe |
| hnd_valid | output | 1 | Handler-select pulse |
| hnd_kind | output | 6 | Winning kind |
| hnd_class | output | 3 | Winning class |
| hnd_status | output | 32 | Packed exception status word |
| hnd_pc | output | 32 | Faulting instruction address |
| hnd_addr | output | 32 | Data address, gated by address-valid |
| hnd_div | output | 2 | Division sub-code |
| ovf | output | 1 | Sticky slot-overflow flag |

## Verification
The bench builds the block with its defaults of four slots and four entries per slot. At that size a fifth request to a single slot reaches the overflow path, and every slot-versus-entry tie order can be set up within a few cycles. A behavioural model tracks all sixteen entries. Directed packets cover each status-word field, the address gating and the tie-breaks. A long stretch of random traffic then mixes invalid kinds, full slots and back-to-back packet ends with the pulse cycle.

// File: rtl/vexq_pkg.sv
package vexq_pkg;

    localparam int KIND_W    = 6;
    localparam int NUM_KINDS = 36;
    localparam int ADDR_W    = 32;
    localparam int SUB_W     = 2;
    localparam int STAT_W    = 32;
    localparam int CLASS_W   = 3;

    localparam logic [KIND_W-1:0] K_TRAP     = 6'd15;
    localparam logic [KIND_W-1:0] K_COMMIT   = 6'd16;
    localparam logic [KIND_W-1:0] K_DIV      = 6'd17;
    localparam logic [KIND_W-1:0] K_DSTORE   = 6'd18;
    localparam logic [KIND_W-1:0] K_DAEXC    = 6'd19;
    localparam logic [KIND_W-1:0] K_DMMU     = 6'd20;
    localparam logic [KIND_W-1:0] K_DAERR    = 6'd21;
    localparam logic [KIND_W-1:0] K_MPEXC    = 6'd22;
    localparam logic [KIND_W-1:0] K_FPEXC    = 6'd23;
    localparam logic [KIND_W-1:0] K_MISAL    = 6'd24;
    localparam logic [KIND_W-1:0] K_REGEXC   = 6'd25;
    localparam logic [KIND_W-1:0] K_MPDIS    = 6'd26;
    localparam logic [KIND_W-1:0] K_FPDIS    = 6'd27;
    localparam logic [KIND_W-1:0] K_PRIV     = 6'd28;
    localparam logic [KIND_W-1:0] K_ILLEGAL  = 6'd29;
    localparam logic [KIND_W-1:0] K_IAEXC    = 6'd30;
    localparam logic [KIND_W-1:0] K_IAERR    = 6'd31;
    localparam logic [KIND_W-1:0] K_IMMU     = 6'd32;
    localparam logic [KIND_W-1:0] K_COMPOUND = 6'd33;
    localparam logic [KIND_W-1:0] K_BREAK    = 6'd34;
    localparam logic [KIND_W-1:0] K_RESET    = 6'd35;

    typedef enum logic [CLASS_W-1:0] {
        CL_EXT   = 3'd0,
        CL_SOFT  = 3'd1,
        CL_PROG  = 3'd2,
        CL_BRK   = 3'd3,
        CL_RST   = 3'd4
    } exc_class_e;

    typedef struct packed {
        logic [KIND_W-1:0] kind;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] addr;
        logic [SUB_W-1:0]  sub;
    } exq_entry_t;

    function automatic exc_class_e class_of(input logic [KIND_W-1:0] k);
        if (k < K_TRAP)         return CL_EXT;
        else if (k == K_TRAP)   return CL_SOFT;
        else if (k < K_BREAK)   return CL_PROG;
        else if (k == K_BREAK)  return CL_BRK;
        else                    return CL_RST;
    endfunction

    function automatic logic [4:0] code_of(input logic [KIND_W-1:0] k);
        case (k)
            K_COMMIT:  return 5'h14;
            K_DIV:     return 5'h13;
            K_DSTORE:  return 5'h00;
            K_DAEXC:   return 5'h12;
            K_DMMU:    return 5'h11;
            K_DAERR:   return 5'h10;
            K_MPEXC:   return 5'h0E;
            K_FPEXC:   return 5'h0D;
            K_MISAL:   return 5'h0B;
            K_REGEXC:  return 5'h0C;
            K_MPDIS:   return 5'h07;
            K_FPDIS:   return 5'h06;
            K_PRIV:    return 5'h04;
            K_ILLEGAL: return 5'h05;
            K_IAEXC:   return 5'h03;
            K_IAERR:   return 5'h02;
            K_IMMU:    return 5'h01;
            default:   return 5'h1F;
        endcase
    endfunction

    function automatic logic has_data_addr(input logic [KIND_W-1:0] k);
        return (k == K_DAEXC) || (k == K_DMMU) || (k == K_DAERR) || (k == K_MISAL);
    endfunction

endpackage

// File: rtl/exq_slot_store.sv
module exq_slot_store
    import vexq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push_i,
    input  logic                   clear_i,
    input  exq_entry_t             ent_i,
    output exq_entry_t [DEPTH-1:0] ent_o,
    output logic [DEPTH-1:0]       vld_o,
    output logic                   drop_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CNT_W-1:0]       cnt;
        exq_entry_t [DEPTH-1:0] ent;
    } slot_state_t;

    slot_state_t s_d, s_q;
    logic        full;

    assign full = (s_q.cnt == CNT_W'(DEPTH));

    always_comb begin
        s_d    = s_q;
        drop_o = 1'b0;
        if (clear_i) begin
            s_d.cnt = '0;
        end else if (push_i) begin
            if (full) begin
                drop_o = 1'b1;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (s_q.cnt == CNT_W'(i)) s_d.ent[i] = ent_i;
                end
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_vld
        assign vld_o[g] = (s_q.cnt > CNT_W'(g));
    end

    assign ent_o = s_q.ent;

endmodule

// File: rtl/exq_pick.sv
module exq_pick
    import vexq_pkg::*;
#(
    parameter int N = 16
) (
    input  exq_entry_t [N-1:0] ent_i,
    input  logic [N-1:0]       vld_i,
    output logic               found_o,
    output exq_entry_t         win_o
);
    always_comb begin
        found_o = 1'b0;
        win_o   = '0;
        // Scan from index 0 upward; only a strictly higher kind displaces,
        // so an earlier index keeps a tie.
        for (int e = 0; e < N; e++) begin
            if (vld_i[e] && (!found_o || (ent_i[e].kind > win_o.kind))) begin
                found_o = 1'b1;
                win_o   = ent_i[e];
            end
        end
    end
endmodule

// File: rtl/exq_status_enc.sv
module exq_status_enc
    import vexq_pkg::*;
(
    input  logic [KIND_W-1:0]  kind_i,
    input  logic [SUB_W-1:0]   sub_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic [STAT_W-1:0]  status_o,
    output logic [CLASS_W-1:0] class_o,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [SUB_W-1:0]   div_o
);
    logic addr_ok;

    assign addr_ok = has_data_addr(kind_i);

    always_comb begin
        status_o      = '0;
        status_o[0]   = 1'b1;
        status_o[5:1] = code_of(kind_i);
        if (kind_i == K_REGEXC) status_o[7:6] = sub_i;
        if (kind_i == K_IAEXC)  status_o[8]   = sub_i[0];
        if (kind_i == K_DAEXC)  status_o[9]   = sub_i[0];
        status_o[11]  = addr_ok;
        class_o       = class_of(kind_i);
        addr_o        = addr_ok ? addr_i : '0;
        div_o         = (kind_i == K_DIV) ? sub_i : '0;
    end
endmodule

// File: rtl/vliw_exc_queue.sv
module vliw_exc_queue
    import vexq_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int DEPTH = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [SLOTS-1:0]               req_valid,
    input  logic [SLOTS-1:0][KIND_W-1:0]   req_kind,
    input  logic [SLOTS-1:0][ADDR_W-1:0]   req_pc,
    input  logic [SLOTS-1:0][ADDR_W-1:0]   req_addr,
    input  logic [SLOTS-1:0][SUB_W-1:0]    req_sub,
    input  logic                           pkt_end,
    output logic                           hnd_valid,
    output logic [KIND_W-1:0]              hnd_kind,
    output logic [CLASS_W-1:0]             hnd_class,
    output logic [STAT_W-1:0]              hnd_status,
    output logic [ADDR_W-1:0]              hnd_pc,
    output logic [ADDR_W-1:0]              hnd_addr,
    output logic [SUB_W-1:0]               hnd_div,
    output logic                           ovf
);
    localparam int N = SLOTS * DEPTH;

    typedef struct packed {
        logic               valid;
        logic [KIND_W-1:0]  kind;
        logic [CLASS_W-1:0] cls;
        logic [STAT_W-1:0]  status;
        logic [ADDR_W-1:0]  pc;
        logic [ADDR_W-1:0]  addr;
        logic [SUB_W-1:0]   div;
        logic               ovf;
    } out_t;

    out_t o_d, o_q;

    exq_entry_t [SLOTS-1:0][DEPTH-1:0] slot_ent;
    logic       [SLOTS-1:0][DEPTH-1:0] slot_vld;
    logic       [SLOTS-1:0]            slot_drop;
    logic       [SLOTS-1:0]            slot_push;
    exq_entry_t [N-1:0]                flat_ent;
    logic       [N-1:0]                flat_vld;

    logic               win_found;
    exq_entry_t         win;
    logic [STAT_W-1:0]  enc_status;
    logic [CLASS_W-1:0] enc_class;
    logic [ADDR_W-1:0]  enc_addr;
    logic [SUB_W-1:0]   enc_div;
    logic               intake_open;

    // Requests are taken only outside the packet-end and pulse cycles.
    assign intake_open = !pkt_end && !o_q.valid;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        exq_entry_t in_ent;
        assign in_ent.kind = req_kind[s];
        assign in_ent.pc   = req_pc[s];
        assign in_ent.addr = req_addr[s];
        assign in_ent.sub  = req_sub[s];
        assign slot_push[s] = req_valid[s] && (req_kind[s] < KIND_W'(NUM_KINDS)) && intake_open;

        exq_slot_store #(.DEPTH(DEPTH)) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .push_i  (slot_push[s]),
            .clear_i (o_q.valid),
            .ent_i   (in_ent),
            .ent_o   (slot_ent[s]),
            .vld_o   (slot_vld[s]),
            .drop_o  (slot_drop[s])
        );
    end

    // Flat index = slot * DEPTH + entry: lower index means lower slot, earlier entry.
    assign flat_ent = slot_ent;
    assign flat_vld = slot_vld;

    exq_pick #(.N(N)) u_pick (
        .ent_i   (flat_ent),
        .vld_i   (flat_vld),
        .found_o (win_found),
        .win_o   (win)
    );

    exq_status_enc u_enc (
        .kind_i   (win.kind),
        .sub_i    (win.sub),
        .addr_i   (win.addr),
        .status_o (enc_status),
        .class_o  (enc_class),
        .addr_o   (enc_addr),
        .div_o    (enc_div)
    );

    always_comb begin
        o_d     = '0;
        o_d.ovf = o_q.ovf | (|slot_drop);
        if (pkt_end && !o_q.valid && win_found) begin
            o_d.valid  = 1'b1;
            o_d.kind   = win.kind;
            o_d.cls    = enc_class;
            o_d.status = enc_status;
            o_d.pc     = win.pc;
            o_d.addr   = enc_addr;
            o_d.div    = enc_div;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign hnd_valid  = o_q.valid;
    assign hnd_kind   = o_q.kind;
    assign hnd_class  = o_q.cls;
    assign hnd_status = o_q.status;
    assign hnd_pc     = o_q.pc;
    assign hnd_addr   = o_q.addr;
    assign hnd_div    = o_q.div;
    assign ovf        = o_q.ovf;

endmodule

// File: rtl/vliw_exc_queue_chk.sv
module vliw_exc_queue_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pkt_end,
    input logic        hnd_valid,
    input logic [5:0]  hnd_kind,
    input logic [2:0]  hnd_class,
    input logic [31:0] hnd_status,
    input logic [31:0] hnd_pc,
    input logic [31:0] hnd_addr,
    input logic [1:0]  hnd_div,
    input logic        ovf
);
    // R2: a pulse always follows a packet-end strobe
    a_r2_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        hnd_valid |-> $past(pkt_end));

    // R2: the pulse lasts one cycle
    a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        hnd_valid |=> !hnd_valid);

    // R3: class is one of the five defined values
    a_r3_class_range: assert property (@(posedge clk) disable iff (!rst_n)
        hnd_valid |-> (hnd_class <= 3'd4));

    // R5: a reported status word always has its valid bit
    a_r5_status_valid: assert property (@(posedge clk) disable iff (!rst_n)
        hnd_valid |-> hnd_status[0]);

    // R7: data address only escapes with address-valid
    a_r7_addr_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !hnd_status[11] |-> (hnd_addr == 32'd0));

    // R8: division sub-code only for a division winner
    a_r8_div_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (hnd_div != 2'd0) |-> (hnd_kind == 6'd17));

    // R9: overflow flag is sticky
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R12: idle outputs are zero
    a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hnd_valid |-> (hnd_kind == 6'd0 && hnd_status == 32'd0 && hnd_pc == 32'd0));
endmodule

bind vliw_exc_queue vliw_exc_queue_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pkt_end    (pkt_end),
    .hnd_valid  (hnd_valid),
    .hnd_kind   (hnd_kind),
    .hnd_class  (hnd_class),
    .hnd_status (hnd_status),
    .hnd_pc     (hnd_pc),
    .hnd_addr   (hnd_addr),
    .hnd_div    (hnd_div),
    .ovf        (ovf)
);

// File: tb/vliw_exc_queue_tb_top.sv
`timescale 1ns/1ps
module vliw_exc_queue_tb_top;
    localparam int S = 4;
    localparam int D = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [S-1:0]       req_valid;
    logic [S-1:0][5:0]  req_kind;
    logic [S-1:0][31:0] req_pc;
    logic [S-1:0][31:0] req_addr;
    logic [S-1:0][1:0]  req_sub;
    logic               pkt_end;
    logic        hnd_valid;
    logic [5:0]  hnd_kind;
    logic [2:0]  hnd_class;
    logic [31:0] hnd_status, hnd_pc, hnd_addr;
    logic [1:0]  hnd_div;
    logic        ovf;

    always #2 clk = ~clk;

    vliw_exc_queue #(.SLOTS(S), .DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_pc(req_pc), .req_addr(req_addr), .req_sub(req_sub), .pkt_end(pkt_end),
        .hnd_valid(hnd_valid), .hnd_kind(hnd_kind), .hnd_class(hnd_class),
        .hnd_status(hnd_status), .hnd_pc(hnd_pc), .hnd_addr(hnd_addr),
        .hnd_div(hnd_div), .ovf(ovf)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // Reference model state
    int          m_cnt [S];
    int          m_kind[S][D];
    logic [31:0] m_pc  [S][D];
    logic [31:0] m_ad  [S][D];
    int          m_sub [S][D];
    bit          e_valid, e_ovf;
    int          e_kind, e_class, e_div;
    logic [31:0] e_status, e_pc, e_addr;

    function automatic int exp_code(int k);
        case (k)
            16: return 'h14; 17: return 'h13; 18: return 'h00; 19: return 'h12;
            20: return 'h11; 21: return 'h10; 22: return 'h0E; 23: return 'h0D;
            24: return 'h0B; 25: return 'h0C; 26: return 'h07; 27: return 'h06;
            28: return 'h04; 29: return 'h05; 30: return 'h03; 31: return 'h02;
            32: return 'h01;
            default: return 'h1F;
        endcase
    endfunction

    function automatic int exp_class(int k);
        if (k <= 14) return 0;
        if (k == 15) return 1;
        if (k <= 33) return 2;
        if (k == 34) return 3;
        return 4;
    endfunction

    function automatic bit is_data(int k);
        return k == 19 || k == 20 || k == 21 || k == 24;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < S; s++) m_cnt[s] = 0;
        e_valid = 0; e_ovf = 0; e_kind = 0; e_class = 0; e_div = 0;
        e_status = 0; e_pc = 0; e_addr = 0;
    endtask

    task automatic model_update();
        bit was_valid;
        was_valid = e_valid;
        e_valid = 0; e_kind = 0; e_class = 0; e_div = 0; e_status = 0; e_pc = 0; e_addr = 0;
        if (was_valid) begin
            for (int s = 0; s < S; s++) m_cnt[s] = 0;
        end else if (pkt_end) begin
            int bs, be, bk;
            bs = -1; be = -1; bk = -1;
            for (int s = 0; s < S; s++)
                for (int e = 0; e < m_cnt[s]; e++)
                    if (m_kind[s][e] > bk) begin bk = m_kind[s][e]; bs = s; be = e; end
            if (bs >= 0) begin
                int sb;
                sb = m_sub[bs][be];
                e_valid  = 1;
                e_kind   = bk;
                e_class  = exp_class(bk);
                e_pc     = m_pc[bs][be];
                e_status = 32'(1 | (exp_code(bk) << 1));
                if (bk == 25) e_status |= 32'(sb << 6);
                if (bk == 30) e_status |= 32'((sb & 1) << 8);
                if (bk == 19) e_status |= 32'((sb & 1) << 9);
                if (is_data(bk)) begin e_status |= 32'h800; e_addr = m_ad[bs][be]; end
                if (bk == 17) e_div = sb;
            end
        end else begin
            for (int s = 0; s < S; s++) begin
                if (req_valid[s] && int'(req_kind[s]) <= 35) begin
                    if (m_cnt[s] < D) begin
                        m_kind[s][m_cnt[s]] = int'(req_kind[s]);
                        m_pc[s][m_cnt[s]]   = req_pc[s];
                        m_ad[s][m_cnt[s]]   = req_addr[s];
                        m_sub[s][m_cnt[s]]  = int'(req_sub[s]);
                        m_cnt[s]++;
                    end else e_ovf = 1;
                end
            end
        end
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 R10 R11 pulse", 32'(hnd_valid), 32'(e_valid));
        chk("R9 overflow", 32'(ovf), 32'(e_ovf));
        chk("R3 kind", 32'(hnd_kind), 32'(e_kind));
        chk("R3 class", 32'(hnd_class), 32'(e_class));
        chk("R5 R6 R7 status", hnd_status, e_status);
        chk("R4 pc", hnd_pc, e_pc);
        chk("R7 addr", hnd_addr, e_addr);
        chk("R8 div", 32'(hnd_div), 32'(e_div));
    endtask

    task automatic idle_inputs();
        req_valid = '0; req_kind = '0; req_pc = '0; req_addr = '0; req_sub = '0; pkt_end = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst_n) model_update(); else model_reset();
        @(negedge clk);
        compare_all();
        idle_inputs();
    endtask

    task automatic rq(int s, int k, logic [31:0] pc, logic [31:0] ad, int sb);
        req_valid[s] = 1; req_kind[s] = 6'(k); req_pc[s] = pc; req_addr[s] = ad; req_sub[s] = 2'(sb);
    endtask

    task automatic end_pkt();
        pkt_end = 1; tick(); tick(); tick();
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        model_reset();
        @(negedge clk);
        tick(); tick();
        rst_n = 1;
        // R1: empty after reset, packet end gives nothing
        tick();
        chk("R1 reset ovf", 32'(ovf), 32'd0);
        end_pkt();
        // R3 R5: single external level 3 in slot 2 -> status 0x3F
        rq(2, 2, 32'h100, 32'h0, 0); tick();
        pkt_end = 1; tick();
        chk("R5 ext status", hnd_status, 32'h3F);
        tick(); tick();
        // R3 R8: division beats trap and level 15
        rq(0, 14, 32'h200, 0, 0); rq(1, 17, 32'h204, 32'h55, 2); rq(3, 15, 32'h20C, 0, 0); tick();
        pkt_end = 1; tick();
        chk("R8 division div", 32'(hnd_div), 32'd2);
        chk("R5 division status", hnd_status, 32'h27);
        tick(); tick();
        // R6 R7: data access exception with address
        rq(1, 19, 32'h300, 32'hCAFE0000, 1); rq(0, 18, 32'h304, 32'h1, 0); tick();
        pkt_end = 1; tick();
        chk("R7 data status", hnd_status, 32'hA25);
        chk("R7 data addr", hnd_addr, 32'hCAFE0000);
        tick(); tick();
        // R6: register exception over misaligned
        rq(0, 24, 32'h400, 32'h8, 0); rq(2, 25, 32'h404, 32'h9, 1); tick();
        pkt_end = 1; tick();
        chk("R6 regexc status", hnd_status, 32'h59);
        chk("R7 regexc addr", hnd_addr, 32'h0);
        tick(); tick();
        // R6: instruction access exception sub bit
        rq(3, 30, 32'h500, 0, 1); tick();
        end_pkt();
        // R4: ties resolved by slot then entry
        rq(3, 23, 32'h600, 0, 0); rq(1, 23, 32'h610, 0, 0); tick();
        rq(1, 23, 32'h614, 0, 0); rq(0, 5, 32'h618, 0, 0); tick();
        pkt_end = 1; tick();
        chk("R4 tie pc", hnd_pc, 32'h610);
        tick(); tick();
        // R10: queue empty after pulse
        pkt_end = 1; tick();
        chk("R10 no pulse", 32'(hnd_valid), 32'd0);
        tick();
        // R9: fifth request to slot 0 dropped
        for (int i = 0; i < 4; i++) begin rq(0, 0, 32'h700 + 32'(i), 0, 0); tick(); end
        rq(0, 35, 32'h7FF, 0, 0); tick();
        chk("R9 ovf set", 32'(ovf), 32'd1);
        pkt_end = 1; tick();
        chk("R9 dropped reset kind", 32'(hnd_kind), 32'd0);
        tick(); tick();
        // R11: bad kind and requests in packet-end cycle ignored
        rq(1, 40, 32'h800, 0, 0); tick();
        rq(2, 35, 32'h804, 0, 0); pkt_end = 1; tick();
        chk("R11 ignored", 32'(hnd_valid), 32'd0);
        tick(); tick();
        // R3: reset class 4 over break
        rq(0, 34, 32'h900, 0, 0); rq(1, 35, 32'h904, 0, 0); tick();
        pkt_end = 1; tick();
        chk("R3 reset class", 32'(hnd_class), 32'd4);
        tick(); tick();
        // R1: mid-run reset clears overflow
        rq(0, 3, 32'hA00, 0, 0); tick();
        rst_n = 0; tick(); rst_n = 1; tick();
        chk("R1 ovf cleared", 32'(ovf), 32'd0);
        end_pkt();
        // Random traffic
        for (int c = 0; c < 3000; c++) begin
            for (int s = 0; s < S; s++)
                if (($urandom % 3) == 0)
                    rq(s, int'($urandom % 40), $urandom, $urandom, int'($urandom % 4));
            pkt_end = (($urandom % 6) == 0);
            tick();
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule